// File: doc/BRIEF.md
# Command-Driven Serial Bus Slave

This block is the slave end of a synchronous serial link that carries data on one shared, half-duplex line. An active-low select frames each transaction. The master supplies the serial clock, and the slave oversamples it on the chip clock, so the slave never needs to know the serial rate. While the slave is deselected it owns the line and presents a buffer-ready flag on it. When select goes low, the slave lets go of the line so that the master can drive the opening command byte.

The command byte picks one of four operations. The master can load a byte address, store a data byte at that address, read the byte stored at that address, or read the two-bit device bus state. All storage is a register-backed array of bytes. Data changes on the leading edge of each clock pulse and is captured on the trailing edge. The idle level of the clock and the bit order come from two static configuration inputs. Exactly one data byte follows each command. After that byte, and after any command that is not recognised, the slave stays off the line until select rises.

Top module: `sdio_cmd_slave`

## Requirements
- R1: In reset, and from three chip clocks after select is seen high onwards, `sdio_oe` is 1 and `sdio_out` equals `buf_ready`.
- R2: Within three chip clocks of select going low, `sdio_oe` drops to 0. It stays 0 for the whole command byte.
- R3: Command 0x05 takes the following byte as the current address.
- R4: Command 0x06 writes the following byte into storage at the current address.
- R5: Command 0x07 returns the byte stored at the current address. Each bit is driven after a leading edge and holds until the next leading edge.
- R6: Command 0x08 returns one byte with bits 7..2 at zero and bits 1..0 equal to `usb_state` (0 suspended, 1 default, 2 addressed, 3 configured).
- R7: Any other command value leaves the address and the storage unchanged. `sdio_oe` stays 0 until select rises.
- R8: With `cfg_lsb_first` = 1, bit 0 of every byte travels first in both directions. With 0, bit 7 travels first. Stored bytes do not depend on the bit order.
- R9: `cfg_cpol` gives the idle clock level. The leading edge leaves that level and the trailing edge returns to it. Input bits are sampled on trailing edges.
- R10: If select rises before a byte is complete, the partial bits are discarded. No address or storage update happens.
- R11: Clock pulses after the single data byte of a transaction have no effect, and the slave does not drive the line.
- R12: The slave never enables its output while the master is driving the line, provided the master follows the turnaround timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the link |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| buf_ready | input | 1 | Buffer flag presented while deselected |
| usb_state | input | 2 | Device bus state code returned by command 0x08 |
| sel_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the master |
| sdio_in | input | 1 | Value seen on the shared data line |
| sdio_out | output | 1 | Value the slave drives onto the line |
| sdio_oe | output | 1 | Slave output enable for the line |

## Verification
The bench drives the line as a master and mixes random cfg settings, addresses, data and commands with directed cases. Select is lifted half-way through both a command byte and a write byte. A design that kept the partial bits would change storage or the address, and this shows up on the next read. Reserved codes and extra trailing bytes are sent as well. A slave that decoded these, or that drove during them, would corrupt the read-back or would trip the contention counter, which watches every cycle. Writing with one bit order and reading back with the other catches any design that stores the wire order instead of the byte value.

// File: rtl/sdio_slave_pkg.sv
package sdio_slave_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bidx_t;

    localparam byte_t OP_ADDR   = 8'h05;
    localparam byte_t OP_WDATA  = 8'h06;
    localparam byte_t OP_RDATA  = 8'h07;
    localparam byte_t OP_STATUS = 8'h08;

    localparam bidx_t LAST_BIT = bidx_t'(BYTE_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RX,
        ST_TX,
        ST_HOLD
    } state_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } clk_ev_t;

    // Bit that goes on the wire in slot idx for the chosen order.
    function automatic logic pick_bit(byte_t b, bidx_t idx, logic lsb_first);
        bidx_t rev;
        rev = LAST_BIT - idx;
        return lsb_first ? b[idx] : b[rev];
    endfunction

    // Accumulate one received bit into a partial byte.
    function automatic byte_t shift_in(byte_t b, logic bit_in, logic lsb_first);
        return lsb_first ? {bit_in, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/sdio_sync.sv
module sdio_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdio_edge.sv
module sdio_edge
    import sdio_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_s,
    input  logic    cpol,
    output clk_ev_t ev
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    // Leading edge leaves the idle level, trailing edge returns to it.
    assign ev.lead  = (sclk_q == cpol) && (sclk_s != cpol);
    assign ev.trail = (sclk_q != cpol) && (sclk_s == cpol);
endmodule

// File: rtl/sdio_store.sv
module sdio_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/sdio_cmd_slave.sv
module sdio_cmd_slave
    import sdio_slave_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_cpol,
    input  logic       cfg_lsb_first,
    input  logic       buf_ready,
    input  logic [1:0] usb_state,
    input  logic       sel_n,
    input  logic       sclk,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe
);
    localparam int PAD_W = BYTE_W - 2;

    logic    sel_s, sclk_s, din_s;
    clk_ev_t ev;
    logic    lead, trail;

    state_e            state;
    bidx_t             cnt;
    byte_t             shreg, sh_next, op;
    byte_t             tx;
    logic              tx_bit, drive;
    logic [ADDR_W-1:0] addr;
    logic              last, mem_we;
    byte_t             rdata;

    sdio_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({sel_n, sclk, sdio_in}),
        .q  ({sel_s, sclk_s, din_s})
    );

    sdio_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .sclk_s(sclk_s),
        .cpol  (cfg_cpol),
        .ev    (ev)
    );

    assign lead  = ev.lead;
    assign trail = ev.trail;

    sdio_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(BYTE_W)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (mem_we),
        .addr (addr),
        .wdata(sh_next),
        .rdata(rdata)
    );

    assign sh_next = shift_in(shreg, din_s, cfg_lsb_first);
    assign last    = (cnt == LAST_BIT);
    assign mem_we  = !sel_s && (state == ST_RX) && trail && last && (op == OP_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            op     <= '0;
            addr   <= '0;
            tx     <= '0;
            tx_bit <= 1'b0;
            drive  <= 1'b0;
        end else if (sel_s) begin
            // Deselect, including mid-byte abort: drop partial bits.
            state <= ST_IDLE;
            cnt   <= '0;
            drive <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state <= ST_CMD;
                    cnt   <= '0;
                    shreg <= '0;
                end
                ST_CMD: begin
                    if (trail) begin
                        shreg <= sh_next;
                        cnt   <= cnt + 1'b1;
                        if (last) begin
                            op  <= sh_next;
                            cnt <= '0;
                            if (sh_next == OP_ADDR || sh_next == OP_WDATA) begin
                                state <= ST_RX;
                            end else if (sh_next == OP_RDATA) begin
                                tx    <= rdata;
                                state <= ST_TX;
                            end else if (sh_next == OP_STATUS) begin
                                tx    <= {{PAD_W{1'b0}}, usb_state};
                                state <= ST_TX;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_RX: begin
                    if (trail) begin
                        shreg <= sh_next;
                        cnt   <= cnt + 1'b1;
                        if (last) begin
                            if (op == OP_ADDR) addr <= sh_next[ADDR_W-1:0];
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_TX: begin
                    if (lead) begin
                        tx_bit <= pick_bit(tx, cnt, cfg_lsb_first);
                        drive  <= 1'b1;
                    end
                    if (trail) begin
                        cnt <= cnt + 1'b1;
                        if (last) begin
                            drive <= 1'b0;
                            state <= ST_HOLD;
                        end
                    end
                end
                default: begin
                    state <= ST_HOLD;
                end
            endcase
        end
    end

    assign sdio_oe  = (state == ST_IDLE) || drive;
    assign sdio_out = (state == ST_IDLE) ? buf_ready : tx_bit;
endmodule

// File: rtl/sdio_cmd_slave_chk.sv
module sdio_cmd_slave_chk
    import sdio_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic   clk,
    input logic   rst,
    input logic   sel_n,
    input logic   buf_ready,
    input logic   sdio_out,
    input logic   sdio_oe,
    input state_e state,
    input byte_t  op,
    input logic   mem_we,
    input logic   lead,
    input logic   tx_bit
);
    localparam int LAT = SYNC_STAGES + 1;

    logic [3:0] hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sel_n  ? ((hi_run == 4'hF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= !sel_n ? ((lo_run == 4'hF) ? lo_run : lo_run + 1'b1) : '0;
        end
    end

    // R1: deselected long enough, slave presents the buffer flag.
    p_idle_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (sel_n && int'(hi_run) >= LAT) |-> (sdio_oe && sdio_out == buf_ready));

    // R2: the line is only released after select has been low long enough.
    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sdio_oe) |-> (!sel_n && int'(lo_run) >= LAT));

    // R5, R6: while selected, only a read command may drive the line.
    p_drive_read_r5: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe && state != ST_IDLE) |-> (op == OP_RDATA || op == OP_STATUS));

    // R4: storage changes only under the write-data command.
    p_write_op_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (op == OP_WDATA && !sel_n));

    // R7, R11: once the transaction is finished or refused, stay off the line.
    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !sdio_oe);

    // R9: a transmitted bit changes only after a leading edge.
    p_lead_only_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && $past(state) == ST_TX && !$past(lead)) |-> $stable(tx_bit));
endmodule

bind sdio_cmd_slave sdio_cmd_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .buf_ready(buf_ready),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .state    (state),
    .op       (op),
    .mem_we   (mem_we),
    .lead     (lead),
    .tx_bit   (tx_bit)
);

// File: tb/sdio_cmd_slave_tb.sv
module sdio_cmd_slave_tb;
    import sdio_slave_pkg::*;

    localparam int HP = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, cfg_cpol, cfg_lsb, buf_ready;
    logic [1:0] usb_state;
    logic       sel_n, sclk, m_oe, m_dout;
    logic       sdio_in, sdio_out, sdio_oe;

    assign sdio_in = m_oe ? m_dout : (sdio_oe ? sdio_out : 1'b1);

    sdio_cmd_slave u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_cpol     (cfg_cpol),
        .cfg_lsb_first(cfg_lsb),
        .buf_ready    (buf_ready),
        .usb_state    (usb_state),
        .sel_n        (sel_n),
        .sclk         (sclk),
        .sdio_in      (sdio_in),
        .sdio_out     (sdio_out),
        .sdio_oe      (sdio_oe)
    );

    int    n_chk = 0, n_bad = 0, n_contend = 0;
    byte_t exp_mem [256];
    byte_t exp_addr;
    int    oe_hits;

    always @(negedge clk) if (m_oe && sdio_oe) n_contend++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic byte_t status_byte(input logic [1:0] u);
        return {6'b0, u};
    endfunction

    task automatic set_cfg(input logic cp, input logic lsb);
        cfg_cpol = cp;
        cfg_lsb  = lsb;
        sclk     = cp;
        wt(HP);
    endtask

    task automatic start_txn();
        sel_n = 1'b0;
        wt(6);
        check("R2 line released after select", {31'b0, sdio_oe}, 32'd0);
    endtask

    task automatic send_byte(input byte_t b, input int nbits);
        m_oe = 1'b1;
        for (int k = 0; k < nbits; k++) begin
            m_dout = cfg_lsb ? b[k] : b[7-k];
            sclk   = ~cfg_cpol;
            wt(HP);
            sclk   = cfg_cpol;
            wt(HP);
        end
    endtask

    task automatic recv_byte(output byte_t b);
        b    = '0;
        m_oe = 1'b0;
        for (int k = 0; k < 8; k++) begin
            sclk = ~cfg_cpol;
            wt(HP);
            if (cfg_lsb) b[k] = sdio_out; else b[7-k] = sdio_out;
            sclk = cfg_cpol;
            wt(HP);
        end
    endtask

    // Clock a byte with no driver and count cycles the slave drives.
    task automatic quiet_byte();
        m_oe    = 1'b0;
        oe_hits = 0;
        for (int k = 0; k < 8; k++) begin
            sclk = ~cfg_cpol;
            for (int c = 0; c < HP; c++) begin wt(1); if (sdio_oe) oe_hits++; end
            sclk = cfg_cpol;
            for (int c = 0; c < HP; c++) begin wt(1); if (sdio_oe) oe_hits++; end
        end
    endtask

    task automatic end_txn();
        m_oe = 1'b0;
        wt(2);
        sel_n = 1'b1;
        wt(HP);
    endtask

    task automatic do_addr(input byte_t a);
        start_txn(); send_byte(OP_ADDR, 8); send_byte(a, 8); end_txn();
        exp_addr = a;
    endtask

    task automatic do_write(input byte_t d, input logic extra);
        start_txn(); send_byte(OP_WDATA, 8); send_byte(d, 8);
        if (extra) send_byte(~d, 8);   // R11: trailing byte is ignored
        end_txn();
        exp_mem[exp_addr] = d;
    endtask

    task automatic do_read(input string req);
        byte_t b;
        start_txn(); send_byte(OP_RDATA, 8);
        wt(1);
        check("R2 off line before read data", {31'b0, sdio_oe}, 32'd0);
        recv_byte(b); end_txn();
        check(req, {24'b0, b}, {24'b0, exp_mem[exp_addr]});
    endtask

    task automatic do_status(input logic [1:0] u);
        byte_t b;
        usb_state = u;
        start_txn(); send_byte(OP_STATUS, 8); recv_byte(b); end_txn();
        check("R6 status byte", {24'b0, b}, {24'b0, status_byte(u)});
    endtask

    task automatic do_reserved(input byte_t c);
        start_txn(); send_byte(c, 8); quiet_byte(); end_txn();
        check("R7 reserved command keeps line released", oe_hits, 0);
    endtask

    task automatic do_idle(input logic v);
        buf_ready = v;
        wt(4);
        check("R1 idle drives buffer flag", {30'b0, sdio_oe, sdio_out}, {30'b0, 1'b1, v});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int    seed_sink;
        byte_t v;
        seed_sink = $urandom(32'd20517);
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        exp_addr = '0;
        rst = 1'b1; cfg_cpol = 1'b0; cfg_lsb = 1'b0; buf_ready = 1'b1;
        usb_state = 2'd0; sel_n = 1'b1; sclk = 1'b0; m_oe = 1'b0; m_dout = 1'b0;
        wt(6);
        check("R1 reset drives flag", {30'b0, sdio_oe, sdio_out}, 32'd3);
        rst = 1'b0;
        wt(4);
        do_idle(1'b0);
        do_idle(1'b1);

        // R3, R4, R5 basic, mode with idle-low clock, bit 7 first
        do_addr(8'h12); do_write(8'hA5, 1'b0); do_read("R5 read back");
        // R9 idle-high clock
        set_cfg(1'b1, 1'b0);
        do_addr(8'h34); do_write(8'h3C, 1'b0); do_read("R9 cpol=1 read back");
        // R8 write with bit 0 first, read with bit 7 first
        set_cfg(1'b0, 1'b1);
        do_addr(8'h40); do_write(8'h81, 1'b0);
        set_cfg(1'b1, 1'b0);
        do_read("R8 order-independent storage");
        set_cfg(1'b1, 1'b1);
        do_read("R8 lsb-first read");
        // R6 all state codes
        for (int u = 0; u < 4; u++) do_status(2'(u));
        // R7 reserved codes then read back
        do_reserved(8'h09); do_reserved(8'h0F); do_reserved(8'h00);
        do_read("R7 reserved leaves storage");
        // R10 aborts mid write byte and mid command byte
        start_txn(); send_byte(OP_WDATA, 8); send_byte(8'hFF, 4); end_txn();
        do_read("R10 aborted write discarded");
        start_txn(); send_byte(OP_ADDR, 3); end_txn();
        do_idle(1'b0);
        do_read("R10 aborted command discarded");
        // R11 extra byte after write data
        do_write(8'h5A, 1'b1);
        do_read("R11 trailing byte ignored");

        for (int it = 0; it < 50; it++) begin
            case ($urandom_range(0, 6))
                0: set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                1: do_addr(8'($urandom_range(0, 7)));
                2: do_write(8'($urandom), 1'($urandom_range(0, 1)));
                3: do_read("R5 random read");
                4: do_status(2'($urandom_range(0, 3)));
                5: begin
                    v = 8'($urandom_range(9, 15));
                    if ($urandom_range(0, 1) == 1) v = 8'($urandom_range(16, 255));
                    do_reserved(v);
                end
                default: begin
                    start_txn(); send_byte(OP_WDATA, 8);
                    send_byte(8'($urandom), $urandom_range(1, 7)); end_txn();
                    do_read("R10 random abort");
                end
            endcase
        end
        do_idle(1'b1);

        check("R12 no bus contention", n_contend, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule